// File: doc/BRIEF.md
# Card Column Capture and Packer

This block receives punched-card columns one at a time and turns them into 16-bit words for a memory write port. Each column is a 12-bit pattern of row punches, captured on a single-cycle column strobe that an upstream stage has already resynchronized to the core clock. Columns arrive far apart, roughly one per millisecond of reader motion, so a word is normally consumed long before the next strobe.

A mode input chooses between two formats. In binary mode every column becomes one word with its row bits unchanged. In character mode each column is translated in hardware from its punch code to an 8-bit character, and two characters are packed into each word. A configuration input gives the number of columns per card, so the same logic serves short 51-column cards and full 80-column cards. The block counts columns, flushes a half-filled word at the end of a card, marks the last word of every card, and offers each word on a valid/ready handshake.

Top module: `card_column_packer`

## Requirements
- R1: After reset, wordValid, lastWord, charError and overrun are all 0.
- R2: In binary mode (modeChar=0) an accepted column produces one word: wordData[11:0] equals colData, and wordData[15:12] is 0. colData bit 11 is row 12, bit 10 is row 11, bit 9 is row 0, and bits 8 down to 0 are rows 1 through 9.
- R3: In character mode a column converts as follows: no punch gives 8'h20; a single digit row d (0..9) alone gives 8'h30+d; row 12 with digit 1..9 gives 8'h40+d; row 11 with digit 1..9 gives 8'h49+d; row 0 with digit 2..9 gives 8'h51+d; row 12 alone gives 8'h26; row 11 alone gives 8'h2D.
- R4: Any other punch pattern converts to 8'h3F and sets charError, which stays 1 until reset.
- R5: In character mode the first column of each pair is placed in wordData[15:8] and the second in wordData[7:0]; a word is produced only when the second column is accepted.
- R6: In character mode, when a card has an odd column count its final column is flushed as a word whose low byte is 8'h20.
- R7: While wordValid is 1 and wordReady is 0, wordValid stays 1 and wordData and lastWord do not change; a word is removed on a cycle with wordValid and wordReady both 1.
- R8: A column strobe seen while wordValid is 1 is dropped: it sets overrun (sticky until reset), leaves the pending word unchanged and is not counted as a column.
- R9: A word produced by a strobe is valid at the clock edge that samples the strobe, so wordValid is 0 during the strobe cycle and 1 in the next.
- R10: Columns are counted per card using colsPerCard; lastWord is 1 exactly on the word that carries the final column of a card, after which counting restarts at the first column.

Ports
## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeChar | input | 1 | 0 = binary format, 1 = character format |
| colsPerCard | input | COL_W | Columns on each card (1 or more) |
| colStrobe | input | 1 | One-cycle pulse marking a new column |
| colData | input | 12 | Row punches of the column |
| wordReady | input | 1 | Memory side accepts the word |
| wordData | output | 16 | Packed word |
| wordValid | output | 1 | wordData holds a word to be written |
| lastWord | output | 1 | Pending word ends a card |
| charError | output | 1 | Sticky invalid-punch flag |
| overrun | output | 1 | Sticky dropped-column flag |

## Verification
The assertions assume colStrobe is a single-cycle pulse, that modeChar and colsPerCard change only between cards (the bench changes them only under reset), and that colsPerCard is never zero. The stimulus sweeps every one of the 4096 column patterns in both formats, with two-column cards for character pairs and 51- and 80-column cards for counting and flush. Overrun is provoked deliberately by strobing while a word is held with wordReady low; elsewhere the bench always consumes each word before the next strobe.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  localparam int ROWS   = 12;
  localparam int WORD_W = 16;
  localparam int CHAR_W = 8;
  localparam int PAD_W  = WORD_W - ROWS;

  localparam logic [CHAR_W-1:0] CH_SPACE = 8'h20;
  localparam logic [CHAR_W-1:0] CH_BAD   = 8'h3F;

  typedef struct packed {
    logic loadBin;
    logic loadHigh;
    logic emitPair;
    logic emitFlush;
    logic convert;
  } ccp_ctl_t;
endpackage

// File: rtl/ccp_hollerith.sv
module ccp_hollerith
  import ccp_pkg::*;
(
  input  logic [ROWS-1:0]   punch,
  output logic [CHAR_W-1:0] charCode,
  output logic              invalid
);
  logic [2:0] zone;
  logic [8:0] digits;
  logic       noDigit;
  logic       oneDigit;
  logic [3:0] dVal;
  logic [CHAR_W-1:0] dExt;

  assign zone     = punch[11:9];
  assign digits   = punch[8:0];
  assign noDigit  = (digits == 9'd0);
  assign oneDigit = !noDigit && ((digits & (digits - 9'd1)) == 9'd0);
  assign dExt     = {4'b0, dVal};

  always_comb begin
    dVal = 4'd0;
    for (int i = 0; i < 9; i++) begin
      if (digits[i]) dVal = 4'(9 - i);
    end
  end

  always_comb begin
    charCode = CH_BAD;
    invalid  = 1'b1;
    unique case (zone)
      3'b000: begin
        if (noDigit)       begin charCode = CH_SPACE;      invalid = 1'b0; end
        else if (oneDigit) begin charCode = 8'h30 + dExt;  invalid = 1'b0; end
      end
      3'b100: begin
        if (noDigit)       begin charCode = 8'h26;         invalid = 1'b0; end
        else if (oneDigit) begin charCode = 8'h40 + dExt;  invalid = 1'b0; end
      end
      3'b010: begin
        if (noDigit)       begin charCode = 8'h2D;         invalid = 1'b0; end
        else if (oneDigit) begin charCode = 8'h49 + dExt;  invalid = 1'b0; end
      end
      3'b001: begin
        if (noDigit)       begin charCode = 8'h30;         invalid = 1'b0; end
        else if (oneDigit && dVal >= 4'd2) begin
          charCode = 8'h51 + dExt; invalid = 1'b0;
        end
      end
      default: begin
        charCode = CH_BAD;
        invalid  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ccp_ctrl.sv
module ccp_ctrl
  import ccp_pkg::*;
#(
  parameter int COL_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeChar,
  input  logic [COL_W-1:0] colsPerCard,
  input  logic             colStrobe,
  input  logic             wordReady,
  output ccp_ctl_t         ctl,
  output logic             wordValid,
  output logic             lastWord,
  output logic             overrun
);
  logic [COL_W-1:0] colIdx;
  logic [COL_W-1:0] lastIdx;
  logic             halfFull;
  logic             accept;
  logic             isLast;
  logic             emit;

  assign lastIdx = colsPerCard - COL_W'(1);
  assign isLast  = (colIdx == lastIdx);
  assign accept  = colStrobe && !wordValid;

  always_comb begin
    ctl.loadBin   = accept && !modeChar;
    ctl.convert   = accept && modeChar;
    ctl.loadHigh  = accept && modeChar && !halfFull && !isLast;
    ctl.emitFlush = accept && modeChar && !halfFull && isLast;
    ctl.emitPair  = accept && modeChar && halfFull;
  end

  assign emit = ctl.loadBin || ctl.emitFlush || ctl.emitPair;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colIdx    <= '0;
      halfFull  <= 1'b0;
      wordValid <= 1'b0;
      lastWord  <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (accept) colIdx <= isLast ? '0 : colIdx + COL_W'(1);

      if (ctl.loadHigh)      halfFull <= 1'b1;
      else if (ctl.emitPair) halfFull <= 1'b0;

      if (emit) begin
        wordValid <= 1'b1;
        lastWord  <= isLast;
      end else if (wordValid && wordReady) begin
        wordValid <= 1'b0;
        lastWord  <= 1'b0;
      end

      if (colStrobe && wordValid) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/ccp_datapath.sv
module ccp_datapath
  import ccp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ccp_ctl_t          ctl,
  input  logic [ROWS-1:0]   colData,
  output logic [WORD_W-1:0] wordData,
  output logic              charError
);
  logic [CHAR_W-1:0] curChar;
  logic              curBad;
  logic [CHAR_W-1:0] hiByte;

  ccp_hollerith u_conv (
    .punch    (colData),
    .charCode (curChar),
    .invalid  (curBad)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiByte    <= '0;
      wordData  <= '0;
      charError <= 1'b0;
    end else begin
      if (ctl.loadHigh)  hiByte   <= curChar;
      if (ctl.loadBin)   wordData <= {{PAD_W{1'b0}}, colData};
      if (ctl.emitFlush) wordData <= {curChar, CH_SPACE};
      if (ctl.emitPair)  wordData <= {hiByte, curChar};
      if (ctl.convert && curBad) charError <= 1'b1;
    end
  end
endmodule

// File: rtl/card_column_packer.sv
module card_column_packer
  import ccp_pkg::*;
#(
  parameter int COL_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeChar,
  input  logic [COL_W-1:0] colsPerCard,
  input  logic             colStrobe,
  input  logic [11:0]      colData,
  input  logic             wordReady,
  output logic [15:0]      wordData,
  output logic             wordValid,
  output logic             lastWord,
  output logic             charError,
  output logic             overrun
);
  ccp_ctl_t ctl;

  ccp_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .modeChar    (modeChar),
    .colsPerCard (colsPerCard),
    .colStrobe   (colStrobe),
    .wordReady   (wordReady),
    .ctl         (ctl),
    .wordValid   (wordValid),
    .lastWord    (lastWord),
    .overrun     (overrun)
  );

  ccp_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .colData   (colData),
    .wordData  (wordData),
    .charError (charError)
  );
endmodule

// File: rtl/ccp_checker.sv
module ccp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        modeChar,
  input logic        colStrobe,
  input logic [11:0] colData,
  input logic        wordReady,
  input logic [15:0] wordData,
  input logic        wordValid,
  input logic        lastWord,
  input logic        charError,
  input logic        overrun
);
  // R7: held word does not move
  a_r7_hold_word: assert property (@(posedge clk) disable iff (!rstN)
    wordValid && !wordReady |=> wordValid && $stable(wordData) && $stable(lastWord));

  // R8: strobe during a pending word raises overrun
  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    colStrobe && wordValid |=> overrun);

  // R8: overrun is sticky
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R4: invalid-punch flag is sticky
  a_r4_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    charError |=> charError);

  // R2 and R9: binary column appears unchanged one edge later
  a_r2_binary_word: assert property (@(posedge clk) disable iff (!rstN)
    colStrobe && !wordValid && !modeChar |=>
      wordValid && (wordData == {4'b0000, $past(colData)}));
endmodule

bind card_column_packer ccp_checker u_ccp_checker (
  .clk       (clk),
  .rstN      (rstN),
  .modeChar  (modeChar),
  .colStrobe (colStrobe),
  .colData   (colData),
  .wordReady (wordReady),
  .wordData  (wordData),
  .wordValid (wordValid),
  .lastWord  (lastWord),
  .charError (charError),
  .overrun   (overrun)
);

// File: tb/tb_card_column_packer.sv
module tb_card_column_packer;
  localparam int COL_W = 7;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             modeChar = 1'b0;
  logic [COL_W-1:0] colsPerCard = 7'd2;
  logic             colStrobe = 1'b0;
  logic [11:0]      colData = '0;
  logic             wordReady = 1'b0;
  logic [15:0]      wordData;
  logic             wordValid;
  logic             lastWord;
  logic             charError;
  logic             overrun;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  card_column_packer #(.COL_W(COL_W)) dut (
    .clk(clk), .rstN(rstN), .modeChar(modeChar), .colsPerCard(colsPerCard),
    .colStrobe(colStrobe), .colData(colData), .wordReady(wordReady),
    .wordData(wordData), .wordValid(wordValid), .lastWord(lastWord),
    .charError(charError), .overrun(overrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected character for a punch pattern, from the R3/R4 rules
  function automatic logic [7:0] expChar(input logic [11:0] p);
    int nd;
    int d;
    logic [2:0] z;
    z  = p[11:9];
    nd = $countones(p[8:0]);
    d  = 0;
    for (int r = 1; r <= 9; r++) if (p[9 - r]) d = r;
    if (nd == 0) begin
      case (z)
        3'b000: return 8'h20;
        3'b100: return 8'h26;
        3'b010: return 8'h2D;
        3'b001: return 8'h30;
        default: return 8'h3F;
      endcase
    end
    if (nd > 1) return 8'h3F;
    case (z)
      3'b000: return 8'(8'h30 + d);
      3'b100: return 8'(8'h40 + d);
      3'b010: return 8'(8'h49 + d);
      3'b001: return (d >= 2) ? 8'(8'h51 + d) : 8'h3F;
      default: return 8'h3F;
    endcase
  endfunction

  function automatic logic [11:0] validPat(input int i);
    logic [11:0] zb;
    int d;
    case (i % 4)
      0: zb = 12'h000;
      1: zb = 12'h800;
      2: zb = 12'h400;
      default: zb = 12'h200;
    endcase
    d = 2 + (i % 8);
    return zb | (12'h001 << (9 - d));
  endfunction

  task automatic doReset(input logic mode, input logic [COL_W-1:0] cols);
    rstN = 1'b0;
    modeChar = mode;
    colsPerCard = cols;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendCol(input logic [11:0] pat, input bit expWord,
                         input logic [15:0] expData, input bit expLast, input string req);
    colData = pat;
    colStrobe = 1'b1;
    @(negedge clk);
    colStrobe = 1'b0;
    check(req, {31'b0, wordValid}, {31'b0, expWord});
    if (expWord) begin
      check(req, {16'b0, wordData}, {16'b0, expData});
      check(req, {31'b0, lastWord}, {31'b0, expLast});
      wordReady = 1'b1;
      @(negedge clk);
      wordReady = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    // R1 reset state
    doReset(1'b0, 7'd51);
    check("R1 wordValid", {31'b0, wordValid}, 32'd0);
    check("R1 lastWord", {31'b0, lastWord}, 32'd0);
    check("R1 charError", {31'b0, charError}, 32'd0);
    check("R1 overrun", {31'b0, overrun}, 32'd0);

    // R9 latency: not valid during strobe cycle, valid after
    colData = 12'hA5C;
    colStrobe = 1'b1;
    #1;
    check("R9 valid during strobe", {31'b0, wordValid}, 32'd0);
    @(negedge clk);
    colStrobe = 1'b0;
    check("R9 valid after strobe", {31'b0, wordValid}, 32'd1);
    wordReady = 1'b1;
    @(negedge clk);
    wordReady = 1'b0;
    check("R7 consumed", {31'b0, wordValid}, 32'd0);

    // R2 R10 exhaustive binary sweep on 51-column cards
    doReset(1'b0, 7'd51);
    for (int i = 0; i < 4096; i++)
      sendCol(12'(i), 1'b1, {4'b0, 12'(i)}, (i % 51) == 50, "R2/R10 binary");

    // R5 R10 80-column card in character mode, all valid
    doReset(1'b1, 7'd80);
    for (int i = 0; i < 80; i += 2) begin
      sendCol(validPat(i), 1'b0, 16'h0, 1'b0, "R5 first half");
      sendCol(validPat(i + 1), 1'b1, {expChar(validPat(i)), expChar(validPat(i + 1))},
              i == 78, "R5/R10 pair");
    end
    check("R4 no error on valid card", {31'b0, charError}, 32'd0);

    // R6 51-column card: odd flush, twice to see count restart
    doReset(1'b1, 7'd51);
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 50; i += 2) begin
        sendCol(validPat(i), 1'b0, 16'h0, 1'b0, "R6 first half");
        sendCol(validPat(i + 1), 1'b1, {expChar(validPat(i)), expChar(validPat(i + 1))},
                1'b0, "R6 pair");
      end
      sendCol(validPat(50), 1'b1, {expChar(validPat(50)), 8'h20}, 1'b1, "R6 flush");
    end

    // R3 R4 exhaustive conversion on two-column cards
    doReset(1'b1, 7'd2);
    sendCol(12'h003, 1'b0, 16'h0, 1'b0, "R4 invalid first half");
    @(negedge clk);
    check("R4 error after invalid", {31'b0, charError}, 32'd1);
    sendCol(12'h000, 1'b1, {8'h3F, 8'h20}, 1'b1, "R4 substitute");
    for (int p = 0; p < 4096; p += 2) begin
      sendCol(12'(p), 1'b0, 16'h0, 1'b0, "R3 first");
      sendCol(12'(p + 1), 1'b1, {expChar(12'(p)), expChar(12'(p + 1))}, 1'b1, "R3/R4 sweep");
    end
    check("R4 error sticky", {31'b0, charError}, 32'd1);

    // R7 R8 hold and overrun in binary mode with 2-column cards
    doReset(1'b0, 7'd2);
    colData = 12'h123;
    colStrobe = 1'b1;
    @(negedge clk);
    colStrobe = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R7 held valid", {31'b0, wordValid}, 32'd1);
      check("R7 held data", {16'b0, wordData}, 32'h0123);
    end
    check("R8 no overrun yet", {31'b0, overrun}, 32'd0);
    colData = 12'hFFF;
    colStrobe = 1'b1;
    @(negedge clk);
    colStrobe = 1'b0;
    check("R8 overrun set", {31'b0, overrun}, 32'd1);
    check("R8 word kept", {16'b0, wordData}, 32'h0123);
    check("R8 last kept", {31'b0, lastWord}, 32'd0);
    wordReady = 1'b1;
    @(negedge clk);
    wordReady = 1'b0;
    sendCol(12'h456, 1'b1, 16'h0456, 1'b1, "R8 dropped column not counted");
    check("R8 overrun sticky", {31'b0, overrun}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule